// File: doc/BRIEF.md
# Four-Queue Shared-Memory FIFO Write Port

This block is the write side of a FIFO that keeps four independent queues in one shared word memory. Every queue gets an equal slice of `DEPTH` words. Data arrives on one common bus, qualified by an active-low write enable. A separate 5-bit address bus, qualified by an address strobe, chooses the queue that later writes go to. The upper three address bits must equal the configured device identifier for a selection to take effect on this device.

A change of queue is pipelined so that the data bus can carry a word on every clock. Words presented on the selection cycle and on the two cycles after it still go into the previously active queue. The full flag moves over to the new queue one edge before that queue starts to accept data. Each queue keeps its own write pointer, read pointer and occupancy count. A small read port, with its own queue select and read enable, drains words so that occupancy and the full flag can be observed.

`DEPTH` must be a power of two and at least 2.

Top module: `mq_wrport`

## Requirements
- R1: The address bus is decoded as follows. Bits [4:2] are compared against `dev_id`, and bits [1:0] give the queue number (0 to 3). A selection takes effect only when bits [4:2] equal `dev_id`.
- R2: A selection is captured on any rising edge where `addr_en` is high, whatever the value of `wr_n`.
- R3: A word with `wr_n` low on the selection edge, or on either of the two edges after it, is stored in the previously active queue, provided that queue is not full.
- R4: From the second edge after the selection edge onward, `full` reflects the newly selected queue. Before that edge, it reflects the old queue.
- R5: From the third edge after the selection edge, writes with `wr_n` low go to the new queue. They keep going there until another selection takes effect.
- R6: `full` is high when the active queue holds `DEPTH` words. A write to a full queue is dropped, whether the queue was full when it was selected or filled later.
- R7: A selection whose device field does not match `dev_id` leaves no queue selected. While no queue is selected, writes are ignored and `full` is low.
- R8: After reset, no queue is selected, every queue is empty (`rd_empty` is high for all values of `rd_q`), `full` is low, `rd_data` is 0, and writes are ignored.
- R9: A read (`rd_en` high) of a non-empty queue `rd_q` places that queue's oldest word on `rd_data` after the edge. A read of an empty queue is ignored, and `rd_data` holds its value.
- R10: A read and a write accepted by the same queue on the same edge leave that queue's occupancy unchanged.
- R11: Each queue stores exactly `DEPTH` words, in first-in, first-out order, independently of the other queues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write and read clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_id | input | 3 | Configured device identifier |
| addr_en | input | 1 | Address strobe; high captures `wr_addr` |
| wr_addr | input | 5 | Device field [4:2], queue number [1:0] |
| wr_n | input | 1 | Active-low write enable |
| wr_data | input | DW | Write data |
| full | output | 1 | Active queue holds DEPTH words |
| rd_en | input | 1 | Read enable |
| rd_q | input | 2 | Queue to read |
| rd_data | output | DW | Word popped by the last accepted read |
| rd_empty | output | 1 | Queue `rd_q` holds no words |

## Verification
A selection made on edge A has three results, each due at a fixed edge. `full` changes after the second edge following A. Writes move to the new queue from the third edge following A. A read's data is valid after the same edge that accepts the read. The directed tasks drive all inputs on the falling edge and sample 1 ns after each rising edge, so every check lands on the exact edge the requirement names: `full` is checked after each of the three switch edges, and words written around a switch are drained from both queues to show which edge each one landed on. `rd_empty` is combinational and is checked without an intervening edge.

// File: rtl/mq_wrport.sv
module mq_wrport #(
  parameter int DW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    dev_id,
  input  logic          addr_en,
  input  logic [4:0]    wr_addr,
  input  logic          wr_n,
  input  logic [DW-1:0] wr_data,
  output logic          full,
  input  logic          rd_en,
  input  logic [1:0]    rd_q,
  output logic [DW-1:0] rd_data,
  output logic          rd_empty
);
  localparam int QN = 4;
  localparam int QW = 2;
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic          hit;
  logic          s1_v, s1_hit, s2_v, s2_hit, wr_valid;
  logic [QW-1:0] s1_q, s2_q, wr_q;
  logic [QN-1:0][PW-1:0] wptr, rptr;
  logic [QN-1:0][CW-1:0] cnt;
  logic [DW-1:0] mem [QN*DEPTH];
  logic          we, re;

  assign hit      = addr_en && (wr_addr[4:2] == dev_id);
  assign full     = wr_valid && (cnt[wr_q] == CW'(DEPTH));
  assign rd_empty = (cnt[rd_q] == '0);
  assign we       = !wr_n && wr_valid && !full;
  assign re       = rd_en && !rd_empty;

  // three-edge queue switch: capture, stage, commit
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s1_hit <= 1'b0; s1_q <= '0;
      s2_v <= 1'b0; s2_hit <= 1'b0; s2_q <= '0;
      wr_valid <= 1'b0; wr_q <= '0;
    end else begin
      s1_v <= addr_en; s1_hit <= hit; s1_q <= wr_addr[1:0];
      s2_v <= s1_v;    s2_hit <= s1_hit; s2_q <= s1_q;
      if (s2_v) begin
        wr_valid <= s2_hit;
        wr_q     <= s2_q;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0; rptr <= '0; cnt <= '0; rd_data <= '0;
    end else begin
      for (int i = 0; i < QN; i++) begin
        case ({we && (wr_q == QW'(i)), re && (rd_q == QW'(i))})
          2'b10:   cnt[i] <= cnt[i] + CW'(1);
          2'b01:   cnt[i] <= cnt[i] - CW'(1);
          default: cnt[i] <= cnt[i];
        endcase
      end
      if (we) wptr[wr_q] <= wptr[wr_q] + PW'(1);
      if (re) begin
        rptr[rd_q] <= rptr[rd_q] + PW'(1);
        rd_data    <= mem[{rd_q, rptr[rd_q]}];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (we) mem[{wr_q, wptr[wr_q]}] <= wr_data;
  end

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !full); // R8
  AST_SWITCH_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n,3) && $past(hit,3)) |-> (wr_valid && wr_q == $past(wr_addr[1:0],3))); // R5
  AST_MISMATCH_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n,3) && $past(addr_en,3) && !$past(hit,3)) |-> (!wr_valid && !full)); // R7
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !s2_v && !(rd_en && rd_q == wr_q)) |=> full); // R6
  AST_EMPTY_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_empty) |=> $stable(rd_data)); // R9
  AST_SAME_Q_OCC: assert property (@(posedge clk) disable iff (!rst_n)
    (we && re && rd_q == wr_q) |=> $stable(cnt)); // R10
endmodule

// File: tb/mq_wrport_bench.sv
module mq_wrport_bench;
  localparam int DW = 8;
  localparam int DEPTH = 4;
  localparam logic [2:0] ID = 3'd5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] dev_id = ID;
  logic addr_en = 1'b0, wr_n = 1'b1, rd_en = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [1:0] rd_q = '0;
  logic full, rd_empty;
  logic [DW-1:0] rd_data;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mq_wrport #(.DW(DW), .DEPTH(DEPTH)) u_mq_wrport (
    .clk(clk), .rst_n(rst_n), .dev_id(dev_id), .addr_en(addr_en),
    .wr_addr(wr_addr), .wr_n(wr_n), .wr_data(wr_data), .full(full),
    .rd_en(rd_en), .rd_q(rd_q), .rd_data(rd_data), .rd_empty(rd_empty));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic wn, input logic [7:0] d, input logic ae,
                      input logic [4:0] a, input logic re, input logic [1:0] q);
    @(negedge clk);
    wr_n = wn; wr_data = d; addr_en = ae; wr_addr = a; rd_en = re; rd_q = q;
    @(posedge clk); #1;
  endtask

  task automatic idle(); step(1'b1, 8'h0, 1'b0, 5'h0, 1'b0, 2'd0); endtask
  task automatic sel(input logic [2:0] dv, input logic [1:0] q);
    step(1'b1, 8'h0, 1'b1, {dv, q}, 1'b0, 2'd0);
  endtask
  task automatic wr(input logic [7:0] d); step(1'b0, d, 1'b0, 5'h0, 1'b0, 2'd0); endtask

  task automatic rd(input logic [1:0] q, input logic [7:0] exp, input string tag);
    step(1'b1, 8'h0, 1'b0, 5'h0, 1'b1, q);
    chk(tag, rd_data, exp);
  endtask

  task automatic chk_empty(input logic [1:0] q, input logic exp, input string tag);
    @(negedge clk);
    wr_n = 1'b1; addr_en = 1'b0; rd_en = 1'b0; rd_q = q;
    #1 chk(tag, rd_empty, exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_n = 1'b1; addr_en = 1'b0; rd_en = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R8 full after reset", full, 0);
    chk("R8 rd_data after reset", rd_data, 0);
    for (int q = 0; q < 4; q++) chk_empty(2'(q), 1'b1, "R8 empty after reset");
    wr(8'hA1); wr(8'hA2);
    for (int q = 0; q < 4; q++) chk_empty(2'(q), 1'b1, "R8 write before select ignored");
    chk("R8 full stays low", full, 0);
  endtask

  task automatic t_switch();
    do_reset();
    sel(ID, 2'd0); idle(); idle();
    step(1'b0, 8'h11, 1'b1, {ID, 2'd1}, 1'b0, 2'd0);
    wr(8'h12); wr(8'h13); wr(8'h14); wr(8'h15); idle();
    rd(2'd0, 8'h11, "R2 R3 word on selection edge to old queue");
    rd(2'd0, 8'h12, "R3 second word to old queue");
    rd(2'd0, 8'h13, "R3 third word to old queue");
    chk_empty(2'd0, 1'b1, "R3 old queue got exactly three");
    rd(2'd1, 8'h14, "R5 first word into new queue");
    rd(2'd1, 8'h15, "R5 writes stay on new queue");
    chk_empty(2'd1, 1'b1, "R5 new queue drained");
    sel(ID, 2'd3); idle(); idle();
    wr(8'h16);
    rd(2'd3, 8'h16, "R1 queue field selects queue 3");
  endtask

  task automatic t_full();
    do_reset();
    sel(ID, 2'd2); idle(); idle();
    wr(8'h20); wr(8'h21); wr(8'h22);
    chk("R6 not full at DEPTH-1", full, 0);
    wr(8'h23);
    chk("R6 R11 full at DEPTH", full, 1);
    wr(8'h24);
    chk("R6 still full after blocked write", full, 1);
    sel(ID, 2'd3);
    chk("R4 full shows old queue after edge A", full, 1);
    idle();
    chk("R4 full shows old queue after edge B", full, 1);
    idle();
    chk("R4 full shows new queue after edge C", full, 0);
    sel(ID, 2'd2);
    chk("R4 edge A still new-empty", full, 0);
    idle();
    chk("R4 edge B still new-empty", full, 0);
    idle();
    chk("R4 R6 full queue selected", full, 1);
    wr(8'h99);
    rd(2'd2, 8'h20, "R11 fifo order 0");
    rd(2'd2, 8'h21, "R11 fifo order 1");
    rd(2'd2, 8'h22, "R11 fifo order 2");
    rd(2'd2, 8'h23, "R6 last stored word");
    chk_empty(2'd2, 1'b1, "R6 blocked writes not stored");
    rd(2'd2, 8'h23, "R9 empty read holds rd_data");
  endtask

  task automatic t_mismatch();
    do_reset();
    sel(ID, 2'd0); idle(); idle();
    wr(8'h30);
    sel(3'd2, 2'd1); idle(); idle();
    chk("R7 full low when deselected", full, 0);
    wr(8'h31); wr(8'h32);
    chk_empty(2'd1, 1'b1, "R1 R7 mismatched queue untouched");
    rd(2'd0, 8'h30, "R7 old queue holds only pre-switch word");
    chk_empty(2'd0, 1'b1, "R7 writes after mismatch ignored");
    sel(ID, 2'd1); idle(); idle();
    wr(8'h33);
    rd(2'd1, 8'h33, "R7 matching select resumes writes");
  endtask

  task automatic t_simul();
    do_reset();
    sel(ID, 2'd1); idle(); idle();
    wr(8'h40); wr(8'h41); wr(8'h42);
    step(1'b0, 8'h43, 1'b0, 5'h0, 1'b1, 2'd1);
    chk("R9 R10 simultaneous read data", rd_data, 8'h40);
    chk("R10 occupancy unchanged", full, 0);
    wr(8'h44);
    chk("R10 one more write fills", full, 1);
    rd(2'd1, 8'h41, "R10 order 1");
    rd(2'd1, 8'h42, "R10 order 2");
    rd(2'd1, 8'h43, "R10 order 3");
    rd(2'd1, 8'h44, "R10 order 4");
    chk_empty(2'd1, 1'b1, "R10 drained");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_switch();
    t_full();
    t_mismatch();
    t_simul();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule